// File: doc/BRIEF.md
# Event-Driven State-Gated Timer

This block is a counter whose every move is decided by a small bank of programmable events. It can count up only, or up and down. Each event watches one of four match registers, and it can also watch an edge or a level on one of two synchronised inputs or on one of the block's own four outputs. An event may watch a match alone, an I/O condition alone, or both. An event is also gated by a 2-bit state variable through a per-event state mask, and by the present count direction.

When an event fires, it can end the count cycle, freeze the counter, pause or resume it, or turn it around. In the same cycle it can drive the outputs high or low, load a new state value and raise a sticky interrupt flag. Because the state variable survives from one count cycle to the next, a sequence can run across several periods. Match register 0 can also end each cycle on its own, with no event configured, so a shared period and independent duty cycles give up to four single-edge PWM waves.

All configuration arrives through a one-cycle write port: an enable, a word address and a data word.

Top module: `evt_timer`

## Requirements
- R1: After reset the count is 0 and the direction is up. The state is 0, all outputs and interrupt flags are 0, and the counter is halted. The count holds at 0 until a control write clears the halt bit.
- R2: Write addresses: 0 is control (bit0 up/down mode, bit1 automatic limit on match 0, bit2 halt, bit3 stop). Addresses 1 to 4 are match registers 0 to 3. Address 5 is the flag-clear mask. Address 16+2e is the condition word of event e, and 17+2e is its action word. A control write takes effect on the next clock edge, and the counter sees the old control value on that edge.
- R3: The condition word is laid out as follows. Bits [1:0] select the match register. Bit 2 makes the match part of the condition. Bit 3 holds a seen match. Bit 4 selects an output instead of an input. Bits [6:5] give the I/O index. Bits [8:7] give the I/O condition (0 none, 1 rising, 2 falling, 3 high level). Bits [10:9] qualify the direction (1 up only, 2 down only, 0 or 3 either). Bits [14:11] are the state mask, where bit s enables state s. An event fires only when every enabled term holds and at least one term is enabled.
- R4: The action word is laid out as follows. Bit0 is limit, bit1 halt, bit2 start, bit3 stop and bit4 reverse. Bits [8:5] are the output set mask and bits [12:9] the output clear mask. Bits [14:13] are the next state, bit15 enables the state load, and bit16 raises the event's interrupt flag. Every action takes effect on the clock edge that ends the cycle in which the event fired.
- R5: In up-only mode, the count returns to 0 on the edge after a cycle in which it equals match 0 with the automatic limit on, or in which a limit action fires. Otherwise it increments.
- R6: In up/down mode, reaching the limit while counting up turns the counter down, and the count steps to limit-1. Reaching 0, or a limit action, while counting down turns it up, and the count steps to 1.
- R7: A halt action freezes the count, and all events stop firing. Only a control write with bit2 clear restarts the counter.
- R8: A stop action pauses the count, but events keep firing. A start action resumes the count. When both fire in the same cycle, stop wins.
- R9: In up/down mode, a reverse action flips the direction and holds the count for that one edge.
- R10: An event fires only in the states enabled by its mask. When several events load the state in the same cycle, the highest-numbered event wins.
- R11: A direction-qualified event fires only while the counter moves in the selected direction.
- R12: For each output, set alone drives 1, clear alone drives 0, and set together with clear toggles. An output with no request holds its value.
- R13: Inputs pass through two flops. A rising or falling condition is true for exactly one cycle, on both inputs and outputs. With hold set, a match is remembered until the I/O condition occurs, and the event then fires.
- R14: Interrupt flags are sticky. A write to address 5 clears the flags whose mask bits are 1, and a new firing in that same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | AW | Configuration word address |
| wr_data | input | DW | Configuration write data |
| ev_in | input | 2 | Asynchronous event inputs |
| ev_out | output | 4 | Event-driven outputs |
| count | output | CW | Current counter value |
| count_down | output | 1 | High while counting down |
| state | output | 2 | Current state variable |
| irq_flags | output | NEV | Sticky per-event interrupt flags |
| irq | output | 1 | OR of all interrupt flags |

## Verification
The bench builds the block with an 8-bit counter and four events. Short match values then give count periods of a few cycles, so wraps, bounces and reversals occur many times within each test. Four events are enough for two events to load the state in the same cycle, for a third to chain the state onward, and for a fourth to halt the counter from a later state. Input and output edge timing is checked with exact cycle counts through the two-flop path.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int CW  = 16,
  parameter int NEV = 6,
  parameter int AW  = 6,
  parameter int DW  = (CW > 17) ? CW : 17
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [1:0]     ev_in,
  output logic [3:0]     ev_out,
  output logic [CW-1:0]  count,
  output logic           count_down,
  output logic [1:0]     state,
  output logic [NEV-1:0] irq_flags,
  output logic           irq
);

  localparam int NM = 4;
  localparam int NO = 4;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_FCLR = AW'(5);

  logic bidir_q, autolim_q, halt_q, stop_q, dir_q;
  logic [CW-1:0] match_q [NM];
  logic [14:0]   cond_q [NEV];
  logic [16:0]   act_q [NEV];
  logic [1:0]    in_s1, in_s2, in_d;
  logic [NO-1:0] out_d;
  logic [NEV-1:0] fire, arm, latch_q, irq_set;

  logic ev_lim, ev_halt, ev_start, ev_stop, ev_rev;
  logic [NO-1:0] set_m, clr_m;
  logic [1:0] nxt_state;
  logic run, at_lim, ctrl_wr;

  assign count_down = bidir_q & dir_q;
  assign irq        = |irq_flags;
  assign run        = !halt_q && !stop_q;
  assign ctrl_wr    = wr_en && (wr_addr == A_CTRL);

  for (genvar g = 0; g < NEV; g++) begin : g_ev
    logic [14:0] c;
    logic [3:0]  smask;
    logic m_now, io_cur, io_prev, io_ok, dir_ok, qual, has_term, m_ok;

    assign c        = cond_q[g];
    assign smask    = c[14:11];
    assign m_now    = (count == match_q[c[1:0]]);
    assign io_cur   = c[4] ? ev_out[c[6:5]] : in_s2[c[5]];
    assign io_prev  = c[4] ? out_d[c[6:5]]  : in_d[c[5]];

    always_comb begin
      case (c[8:7])
        2'd0:    io_ok = 1'b1;
        2'd1:    io_ok = io_cur & ~io_prev;
        2'd2:    io_ok = ~io_cur & io_prev;
        default: io_ok = io_cur;
      endcase
    end

    assign dir_ok   = (c[10:9] == 2'd1) ? !count_down :
                      (c[10:9] == 2'd2) ?  count_down : 1'b1;
    assign qual     = !halt_q && smask[state] && dir_ok;
    assign has_term = c[2] || (c[8:7] != 2'd0);
    assign m_ok     = !c[2] || m_now || (c[3] && latch_q[g]);
    assign fire[g]  = qual && has_term && io_ok && m_ok;
    assign arm[g]   = qual && c[2] && c[3] && m_now;
  end

  always_comb begin
    ev_lim = 1'b0; ev_halt = 1'b0; ev_start = 1'b0; ev_stop = 1'b0; ev_rev = 1'b0;
    set_m = '0; clr_m = '0; nxt_state = state; irq_set = '0;
    for (int e = 0; e < NEV; e++) begin
      if (fire[e]) begin
        ev_lim   |= act_q[e][0];
        ev_halt  |= act_q[e][1];
        ev_start |= act_q[e][2];
        ev_stop  |= act_q[e][3];
        ev_rev   |= act_q[e][4];
        set_m    |= act_q[e][8:5];
        clr_m    |= act_q[e][12:9];
        if (act_q[e][15]) nxt_state = act_q[e][14:13];
        irq_set[e] = act_q[e][16];
      end
    end
  end

  assign at_lim = ev_lim || (autolim_q && (count == match_q[0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      dir_q <= 1'b0;
    end else if (!bidir_q) begin
      dir_q <= 1'b0;
      if (run) count <= at_lim ? '0 : count + 1'b1;
    end else if (run) begin
      if (ev_rev) begin
        dir_q <= ~dir_q;
      end else if (!dir_q) begin
        if (at_lim) begin
          dir_q <= 1'b1;
          count <= count - 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end else if (count == '0 || ev_lim) begin
        dir_q <= 1'b0;
        count <= count + 1'b1;
      end else begin
        count <= count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bidir_q   <= 1'b0;
      autolim_q <= 1'b0;
      halt_q    <= 1'b1;
      stop_q    <= 1'b0;
    end else if (ctrl_wr) begin
      bidir_q   <= wr_data[0];
      autolim_q <= wr_data[1];
      halt_q    <= wr_data[2];
      stop_q    <= wr_data[3];
    end else begin
      if (ev_halt) halt_q <= 1'b1;
      if (ev_stop) stop_q <= 1'b1;
      else if (ev_start) stop_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NM; i++) match_q[i] <= '0;
      for (int e = 0; e < NEV; e++) begin
        cond_q[e] <= '0;
        act_q[e]  <= '0;
      end
      latch_q <= '0;
    end else begin
      for (int i = 0; i < NM; i++)
        if (wr_en && wr_addr == AW'(1 + i)) match_q[i] <= wr_data[CW-1:0];
      for (int e = 0; e < NEV; e++) begin
        if (wr_en && wr_addr == AW'(16 + 2 * e)) begin
          cond_q[e]  <= wr_data[14:0];
          latch_q[e] <= 1'b0;
        end else if (fire[e]) begin
          latch_q[e] <= 1'b0;
        end else if (arm[e]) begin
          latch_q[e] <= 1'b1;
        end
        if (wr_en && wr_addr == AW'(17 + 2 * e)) act_q[e] <= wr_data[16:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_s1 <= '0; in_s2 <= '0; in_d <= '0;
      out_d <= '0; ev_out <= '0;
      state <= '0; irq_flags <= '0;
    end else begin
      in_s1 <= ev_in;
      in_s2 <= in_s1;
      in_d  <= in_s2;
      out_d <= ev_out;
      state <= nxt_state;
      for (int i = 0; i < NO; i++) begin
        case ({set_m[i], clr_m[i]})
          2'b10:   ev_out[i] <= 1'b1;
          2'b01:   ev_out[i] <= 1'b0;
          2'b11:   ev_out[i] <= ~ev_out[i];
          default: ev_out[i] <= ev_out[i];
        endcase
      end
      irq_flags <= (irq_flags & ~((wr_en && wr_addr == A_FCLR) ? wr_data[NEV-1:0] : '0)) | irq_set;
    end
  end

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CW  = 16,
  parameter int NEV = 6,
  parameter int AW  = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic [CW-1:0]  count,
  input logic           count_down,
  input logic [1:0]     state,
  input logic [3:0]     ev_out,
  input logic [NEV-1:0] irq_flags,
  input logic           halt_q,
  input logic           stop_q,
  input logic           bidir_q,
  input logic           autolim_q,
  input logic [CW-1:0]  match0,
  input logic [NEV-1:0] fire,
  input logic           ev_rev
);

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> $stable(count)); // R7

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> $stable(count)); // R8

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && !stop_q && !bidir_q && autolim_q && count == match0) |=> (count == '0)); // R5

  AST_FLOOR_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && !stop_q && bidir_q && count_down && count == '0 && !ev_rev)
      |=> (count == CW'(1) && !count_down)); // R6

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire == '0) |=> $stable(state)); // R10

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire == '0) |=> $stable(ev_out)); // R12

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == AW'(5)) |=> ((irq_flags & $past(irq_flags)) == $past(irq_flags))); // R14

endmodule

bind evt_timer evt_timer_chk #(.CW(CW), .NEV(NEV), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .count(count), .count_down(count_down), .state(state), .ev_out(ev_out),
  .irq_flags(irq_flags), .halt_q(halt_q), .stop_q(stop_q), .bidir_q(bidir_q),
  .autolim_q(autolim_q), .match0(match_q[0]), .fire(fire), .ev_rev(ev_rev)
);

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
  localparam int CW = 8;
  localparam int NEV = 4;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [16:0] wr_data = '0;
  logic [1:0] ev_in = '0;
  logic [3:0] ev_out;
  logic [CW-1:0] count;
  logic count_down;
  logic [1:0] state;
  logic [NEV-1:0] irq_flags;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  evt_timer #(.CW(CW), .NEV(NEV), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ev_in(ev_in), .ev_out(ev_out), .count(count), .count_down(count_down),
    .state(state), .irq_flags(irq_flags), .irq(irq)
  );

  always #2 clk = ~clk;

  // {cycles after start, expected count, expected outputs}
  localparam logic [23:0] PWM_VEC [7] = '{
    {8'd5,  8'd5, 8'h0}, {8'd10, 8'd0, 8'h3}, {8'd13, 8'd3, 8'h3},
    {8'd14, 8'd4, 8'h2}, {8'd16, 8'd6, 8'h2}, {8'd17, 8'd7, 8'h0},
    {8'd20, 8'd0, 8'h3}
  };

  function automatic logic [16:0] mk_cond(input int msel, muse, hold, isout, idx, cnd, dq, mask);
    return 17'({1'b0, 4'(mask), 2'(dq), 2'(cnd), 2'(idx), 1'(isout), 1'(hold), 1'(muse), 2'(msel)});
  endfunction

  function automatic logic [16:0] mk_act(input int lim, hlt, sta, stp, rev, setm, clrm, ns, ld, irqe);
    return {1'(irqe), 1'(ld), 2'(ns), 4'(clrm), 4'(setm), 1'(rev), 1'(stp), 1'(sta), 1'(hlt), 1'(lim)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [16:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ev_in = '0; wr_en = 1'b0;
    adv(2);
    rst_n = 1'b1;
    adv(1);
  endtask

  task automatic set_ev(input int e, input logic [16:0] c, input logic [16:0] a);
    wr(16 + 2 * e, c);
    wr(17 + 2 * e, a);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    do_reset();

    // R1 reset state
    chk("R1 count", 32'(count), 0);
    chk("R1 state", 32'(state), 0);
    chk("R1 outputs", 32'(ev_out), 0);
    chk("R1 flags", 32'(irq_flags), 0);
    chk("R1 direction", 32'(count_down), 0);
    adv(5);
    chk("R1 halted count", 32'(count), 0);

    // PWM with automatic limit (R2 R3 R4 R5 R12)
    do_reset();
    wr(1, 17'd9); wr(2, 17'd3); wr(3, 17'd6);
    set_ev(0, mk_cond(0,1,0,0,0,0,0,15), mk_act(0,0,0,0,0,3,0,0,0,1));
    set_ev(1, mk_cond(1,1,0,0,0,0,0,15), mk_act(0,0,0,0,0,0,1,0,0,0));
    set_ev(2, mk_cond(2,1,0,0,0,0,0,15), mk_act(0,0,0,0,0,0,2,0,0,0));
    wr(0, 17'd2);
    k = 0;
    for (int i = 0; i < 7; i++) begin
      adv(int'(PWM_VEC[i][23:16]) - k);
      k = int'(PWM_VEC[i][23:16]);
      chk("R2 R5 pwm count", 32'(count), 32'(PWM_VEC[i][15:8]));
      chk("R3 R4 R12 pwm outputs", 32'(ev_out), 32'(PWM_VEC[i][3:0]));
    end
    chk("R14 flag raised", 32'(irq_flags), 1);
    chk("R14 irq line", 32'(irq), 1);
    wr(5, 17'd1);
    chk("R14 flag cleared", 32'(irq_flags), 0);
    adv(9);
    chk("R14 flag raised again", 32'(irq_flags), 1);

    // R6 bidirectional, R11 down-only toggle
    do_reset();
    wr(1, 17'd4); wr(2, 17'd2);
    set_ev(0, mk_cond(1,1,0,0,0,0,2,15), mk_act(0,0,0,0,0,4,4,0,0,0));
    wr(0, 17'd3);
    adv(3);  chk("R11 no fire while up", 32'(ev_out), 0);
    adv(1);  chk("R6 top count", 32'(count), 4); chk("R6 still up", 32'(count_down), 0);
    adv(1);  chk("R6 turned down", 32'(count), 3); chk("R6 down flag", 32'(count_down), 1);
    adv(2);  chk("R11 R12 toggle on down pass", 32'(ev_out), 4);
    adv(1);  chk("R6 floor count", 32'(count), 0); chk("R6 floor dir", 32'(count_down), 1);
    adv(1);  chk("R6 turned up", 32'(count), 1); chk("R6 up flag", 32'(count_down), 0);
    adv(3);  chk("R11 held on up pass", 32'(ev_out), 4);
    adv(3);  chk("R12 toggle back", 32'(ev_out), 0);

    // R5 limit action without automatic limit
    do_reset();
    wr(2, 17'd3);
    set_ev(0, mk_cond(1,1,0,0,0,0,0,15), mk_act(1,0,0,0,0,0,0,0,0,0));
    wr(0, 17'd0);
    adv(3); chk("R5 limit reached", 32'(count), 3);
    adv(1); chk("R5 limit wrap", 32'(count), 0);
    adv(4); chk("R5 limit wrap again", 32'(count), 0);

    // R10 state gating and priority, R7 halt
    do_reset();
    wr(1, 17'd9); wr(3, 17'd5);
    set_ev(0, mk_cond(0,1,0,0,0,0,0,1), mk_act(0,0,0,0,0,0,0,1,1,0));
    set_ev(1, mk_cond(0,1,0,0,0,0,0,8), mk_act(0,0,0,0,0,0,0,2,1,0));
    set_ev(2, mk_cond(0,1,0,0,0,0,0,1), mk_act(0,0,0,0,0,0,0,3,1,0));
    set_ev(3, mk_cond(2,1,0,0,0,0,0,4), mk_act(0,1,0,0,0,0,0,0,0,0));
    wr(0, 17'd2);
    adv(9);  chk("R10 initial state", 32'(state), 0);
    adv(1);  chk("R10 highest event wins", 32'(state), 3);
    adv(10); chk("R10 chained state", 32'(state), 2);
    adv(5);  chk("R10 count before halt", 32'(count), 5);
    adv(1);  chk("R7 halt edge", 32'(count), 6);
    adv(4);  chk("R7 frozen", 32'(count), 6);
    wr(0, 17'd2);
    chk("R7 clear edge", 32'(count), 6);
    adv(1);  chk("R7 resumed", 32'(count), 7);

    // R8 stop/start on input edges, R13 sync timing
    do_reset();
    set_ev(0, mk_cond(0,0,0,0,0,1,0,15), mk_act(0,0,0,1,0,0,0,0,0,0));
    set_ev(1, mk_cond(0,0,0,0,1,1,0,15), mk_act(0,0,1,0,0,0,0,0,0,0));
    wr(0, 17'd0);
    adv(3);  chk("R8 running", 32'(count), 3);
    ev_in = 2'b01;
    adv(6);  chk("R8 R13 stopped after sync", 32'(count), 6);
    adv(3);  chk("R8 stays stopped", 32'(count), 6);
    ev_in = 2'b11;
    adv(6);  chk("R8 R13 restarted", 32'(count), 9);
    ev_in = 2'b00;
    adv(3);  chk("R13 falling ignored", 32'(count), 12);
    ev_in = 2'b11;
    adv(6);  chk("R8 stop wins", 32'(count), 15);
    adv(3);  chk("R8 stop wins held", 32'(count), 15);

    // R13 held match, output edge
    do_reset();
    wr(1, 17'd9); wr(2, 17'd2);
    set_ev(0, mk_cond(1,1,1,0,0,1,0,15), mk_act(0,0,0,0,0,8,0,0,0,0));
    set_ev(1, mk_cond(0,0,0,1,3,1,0,15), mk_act(0,0,0,0,0,0,0,0,0,1));
    set_ev(2, mk_cond(1,1,0,0,0,1,0,15), mk_act(0,0,0,0,0,4,0,0,0,0));
    wr(0, 17'd2);
    adv(5);  chk("R13 no early fire", 32'(ev_out), 0);
    ev_in = 2'b01;
    adv(3);  chk("R13 held match fires", 32'(ev_out), 8);
    chk("R13 output edge pending", 32'(irq_flags), 0);
    adv(1);  chk("R13 output rising edge", 32'(irq_flags), 2);

    // R9 reverse action
    do_reset();
    wr(1, 17'd20); wr(2, 17'd5);
    set_ev(0, mk_cond(1,1,0,0,0,0,1,15), mk_act(0,0,0,0,1,0,0,0,0,0));
    wr(0, 17'd3);
    adv(5);  chk("R9 before reverse", 32'(count), 5);
    adv(1);  chk("R9 held count", 32'(count), 5); chk("R9 flipped dir", 32'(count_down), 1);
    adv(1);  chk("R9 counting down", 32'(count), 4);
    adv(10); chk("R9 second reverse", 32'(count_down), 1);
    chk("R9 second hold", 32'(count), 5);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule